// File: doc/BRIEF.md
# Hamming ECC Syndrome Corrector

This block decides what to do after a 256-byte flash block has been read back. It takes the 3-byte Hamming code that was stored with the block and the 3-byte code recomputed over the data as read. It XORs the two codes into a 24-bit syndrome and classifies the result. The four classes are: a clean block, a single flipped data bit that can be repaired, a single flipped bit inside the stored code (the data is good), or damage that cannot be repaired. For a repairable data bit it reports the byte offset within the block, the bit index within that byte and a one-hot flip mask. Writing the repaired byte back into the buffer is left to the caller.

A check starts with a one-cycle strobe while both codes are presented. The result appears on the outputs one clock later with a one-cycle valid pulse. It stays on the outputs until the next strobe.

Top module: `ecc_syn_fix`

## Requirements
- R1: Code byte k (k = 0, 1, 2) sits in bits [8k+7:8k] of `calcEcc` and `readEcc`, and the syndrome byte sk is their XOR. An all-zero syndrome gives `resStatus` = 2'b00 (clean).
- R2: If, in s0 and in s1, every bit pair (7,6), (5,4), (3,2), (1,0) holds two different values, and in s2 the pairs (7,6), (5,4), (3,2) hold two different values, then `resStatus` = 2'b01 (data bit repairable). Bits 1:0 of s2 do not affect this decision.
- R3: For status 2'b01, `errByte` = {s0[7], s0[5], s0[3], s0[1], s1[7], s1[5], s1[3], s1[1]}, with the MSB first.
- R4: For status 2'b01, `errBit` = {s2[7], s2[5], s2[3]}, with the MSB first, and `errMask` = 1 << `errBit`.
- R5: If R2 does not match and exactly one of the 24 syndrome bits is set, `resStatus` = 2'b10 (stored code wrong, data good).
- R6: Any other non-zero syndrome gives `resStatus` = 2'b11 (uncorrectable).
- R7: `resValid` is high for exactly the one cycle after each cycle in which `checkStb` is high, and is low at all other times.
- R8: When `checkStb` is low, all result outputs keep their values, whatever happens on the code inputs.
- R9: When the status is not 2'b01, `errByte`, `errBit` and `errMask` are all zero.
- R10: While `rstN` is low, `resValid` is 0, `resStatus` is 2'b00 and all location outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| checkStb | input | 1 | One-cycle request to classify the presented codes |
| calcEcc | input | 24 | Code recomputed over the data read |
| readEcc | input | 24 | Code stored in flash |
| resValid | output | 1 | Result pulse, one cycle after the strobe |
| resStatus | output | 2 | 00 clean, 01 data bit, 10 code bit, 11 uncorrectable |
| errByte | output | 8 | Byte offset of the bad data bit |
| errBit | output | 3 | Bit index of the bad data bit |
| errMask | output | 8 | One-hot mask used to flip the bad bit |

## Verification
Random codes almost never produce a syndrome in which every constrained pair is complementary. The same holds for a syndrome with exactly one bit set, so the repairable classes are unreachable by chance. The stimulus therefore builds each syndrome on purpose. It sweeps all 2048 byte/bit locations, writing each address and bit index into complementary pairs, and sets random don't-care bits in s2[1:0]. It also flips each of the 24 code bits on its own. Random base codes are XORed with these syndromes, and fully random pairs are mixed in to exercise the uncorrectable class.

// File: rtl/ecc_syn_pkg.sv
package ecc_syn_pkg;
  localparam int CODE_BYTES  = 3;
  localparam int CODE_W      = 8 * CODE_BYTES;
  localparam int BLOCK_BYTES = 256;
  localparam int ADDR_W      = $clog2(BLOCK_BYTES);
  localparam int LANE_W      = 8;
  localparam int BIT_W       = $clog2(LANE_W);

  typedef enum logic [1:0] {
    ST_CLEAN   = 2'b00,
    ST_DATAFIX = 2'b01,
    ST_CODEFIX = 2'b10,
    ST_FATAL   = 2'b11
  } statusT;

  typedef struct packed {
    logic load;
    logic pulse;
  } ctrlT;
endpackage

// File: rtl/ecc_syn_ctrl.sv
module ecc_syn_ctrl
  import ecc_syn_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic checkStb,
  output ctrlT ctrl
);
  logic pendQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pendQ <= 1'b0;
    else       pendQ <= checkStb;
  end

  always_comb begin
    ctrl.load  = checkStb;
    ctrl.pulse = pendQ;
  end

  AST_PULSE_AFTER_STB: assert property (@(posedge clk) disable iff (!rstN)
    checkStb |=> ctrl.pulse); // R7
  AST_NO_STRAY_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    !checkStb |=> !ctrl.pulse); // R7
endmodule

// File: rtl/ecc_syn_dp.sv
module ecc_syn_dp
  import ecc_syn_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlT              ctrl,
  input  logic [CODE_W-1:0] calcEcc,
  input  logic [CODE_W-1:0] readEcc,
  output statusT            status,
  output logic [ADDR_W-1:0] errByte,
  output logic [BIT_W-1:0]  errBit,
  output logic [LANE_W-1:0] errMask
);
  localparam int PAIRS = LANE_W / 2;

  logic [CODE_W-1:0] synd;
  logic [PAIRS-1:0]  pairOk [CODE_BYTES];
  logic              dataErr, singleBit;
  logic [ADDR_W-1:0] addrNext;
  logic [BIT_W-1:0]  bitNext;
  statusT            statusNext;

  assign synd = calcEcc ^ readEcc;

  for (genvar b = 0; b < CODE_BYTES; b++) begin : gByte
    for (genvar p = 0; p < PAIRS; p++) begin : gPair
      assign pairOk[b][p] = synd[8*b + 2*p + 1] ^ synd[8*b + 2*p];
    end
  end

  // last code byte leaves its lowest pair unconstrained
  assign dataErr = (&pairOk[0]) & (&pairOk[1]) & (&pairOk[2][PAIRS-1:1]);

  for (genvar i = 0; i < PAIRS; i++) begin : gAddr
    assign addrNext[ADDR_W-1-i]     = synd[LANE_W-1-2*i];
    assign addrNext[ADDR_W-1-PAIRS-i] = synd[8 + LANE_W-1-2*i];
  end

  for (genvar i = 0; i < BIT_W; i++) begin : gBit
    assign bitNext[BIT_W-1-i] = synd[16 + LANE_W-1-2*i];
  end

  assign singleBit = (synd != '0) && ((synd & (synd - 1'b1)) == '0);

  always_comb begin
    if (synd == '0)     statusNext = ST_CLEAN;
    else if (dataErr)   statusNext = ST_DATAFIX;
    else if (singleBit) statusNext = ST_CODEFIX;
    else                statusNext = ST_FATAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      status  <= ST_CLEAN;
      errByte <= '0;
      errBit  <= '0;
      errMask <= '0;
    end else if (ctrl.load) begin
      status <= statusNext;
      if (statusNext == ST_DATAFIX) begin
        errByte <= addrNext;
        errBit  <= bitNext;
        errMask <= LANE_W'(1) << bitNext;
      end else begin
        errByte <= '0;
        errBit  <= '0;
        errMask <= '0;
      end
    end
  end

  AST_CLEAN_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && calcEcc == readEcc) |=> status == ST_CLEAN); // R1
  AST_MASK_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    (status == ST_DATAFIX) |-> ($onehot(errMask) && errMask[errBit])); // R4
  AST_ONE_BIT_NOT_FATAL: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && $countones(calcEcc ^ readEcc) == 1) |=> status != ST_FATAL); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(status) && $stable(errByte) && $stable(errMask))); // R8
  AST_LOC_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (status != ST_DATAFIX) |-> (errByte == '0 && errBit == '0 && errMask == '0)); // R9
endmodule

// File: rtl/ecc_syn_fix.sv
module ecc_syn_fix
  import ecc_syn_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        checkStb,
  input  logic [23:0] calcEcc,
  input  logic [23:0] readEcc,
  output logic        resValid,
  output logic [1:0]  resStatus,
  output logic [7:0]  errByte,
  output logic [2:0]  errBit,
  output logic [7:0]  errMask
);
  ctrlT   ctrl;
  statusT status;

  ecc_syn_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .checkStb(checkStb), .ctrl(ctrl)
  );

  ecc_syn_dp uDp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl),
    .calcEcc(calcEcc), .readEcc(readEcc),
    .status(status), .errByte(errByte), .errBit(errBit), .errMask(errMask)
  );

  assign resValid  = ctrl.pulse;
  assign resStatus = status;
endmodule

// File: tb/tb_ecc_syn_fix.sv
module tb_ecc_syn_fix;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        checkStb = 1'b0;
  logic [23:0] calcEcc = '0, readEcc = '0;
  logic        resValid;
  logic [1:0]  resStatus;
  logic [7:0]  errByte, errMask;
  logic [2:0]  errBit;

  int checks = 0, fails = 0, cyc = 0;

  ecc_syn_fix dut (.*);

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run hung, actual cyc=%0d expected <150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // reference classification written from the requirements
  function automatic logic [1:0] refStatus(logic [23:0] s);
    logic ok;
    ok = 1'b1;
    for (int p = 0; p < 4; p++) begin
      if (s[2*p+1] == s[2*p]) ok = 1'b0;
      if (s[8+2*p+1] == s[8+2*p]) ok = 1'b0;
      if (p > 0 && s[16+2*p+1] == s[16+2*p]) ok = 1'b0;
    end
    if (s == 0) return 2'b00;
    if (ok) return 2'b01;
    if ($countones(s) == 1) return 2'b10;
    return 2'b11;
  endfunction

  // syndrome for a data error at (addr, bit), with don't-care bits lo
  function automatic logic [23:0] mkSynd(logic [7:0] a, logic [2:0] b, logic [1:0] lo);
    logic [23:0] s;
    for (int i = 0; i < 4; i++) begin
      s[7-2*i -: 2]  = a[7-i]   ? 2'b10 : 2'b01;
      s[15-2*i -: 2] = a[3-i]   ? 2'b10 : 2'b01;
    end
    for (int i = 0; i < 3; i++) s[23-2*i -: 2] = b[2-i] ? 2'b10 : 2'b01;
    s[17:16] = lo;
    return s;
  endfunction

  task automatic runOne(logic [23:0] c, logic [23:0] r, bit holdTest);
    logic [23:0] s;
    logic [1:0]  es;
    s  = c ^ r;
    es = refStatus(s);
    @(negedge clk);
    calcEcc = c; readEcc = r; checkStb = 1'b1;
    @(negedge clk);
    checkStb = 1'b0;
    chk("R7 valid", resValid, 1);
    case (es)
      2'b00: chk("R1 status", resStatus, es);
      2'b01: chk("R2 status", resStatus, es);
      2'b10: chk("R5 status", resStatus, es);
      default: chk("R6 status", resStatus, es);
    endcase
    if (es == 2'b01) begin
      chk("R3 byte", errByte, {s[7], s[5], s[3], s[1], s[15], s[13], s[11], s[9]});
      chk("R4 bit", errBit, {s[23], s[21], s[19]});
      chk("R4 mask", errMask, 8'd1 << {s[23], s[21], s[19]});
    end else begin
      chk("R9 loc", {errByte, errBit, errMask}, 0);
    end
    if (holdTest) begin
      calcEcc = $urandom; readEcc = $urandom;
      @(negedge clk);
      chk("R7 pulse width", resValid, 0);
      chk("R8 hold", resStatus, es);
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    #1;
    chk("R10 valid", resValid, 0);
    chk("R10 status", resStatus, 0);
    chk("R10 loc", {errByte, errBit, errMask}, 0);
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    runOne(24'h123456, 24'h123456, 1'b1);           // R1 clean
    runOne(24'hFFFFFF, 24'h000000, 1'b1);           // R6 all flipped
    for (int a = 0; a < 256; a++)
      for (int b = 0; b < 8; b++) begin
        logic [23:0] base;
        base = $urandom;
        runOne(base, base ^ mkSynd(a[7:0], b[2:0], 2'($urandom)), (a % 37) == 0);
      end
    for (int k = 0; k < 24; k++) begin
      logic [23:0] base;
      base = $urandom;
      runOne(base, base ^ (24'd1 << k), 1'b1);      // R5 single code bit
    end
    for (int n = 0; n < 600; n++) begin
      logic [23:0] base, flip;
      base = $urandom;
      flip = (n % 3 == 0) ? (24'd1 << ($urandom % 24)) | (24'd1 << ($urandom % 24)) : 24'($urandom);
      runOne(base, base ^ flip, (n % 5) == 0);      // R6 mixed
    end

    @(negedge clk);
    chk("R7 idle", resValid, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule